// File: doc/BRIEF.md
# L2 Data RAM Write Strobe Sequencer

This block turns a single write request from a processor bus interface into the chip-select, output-enable, per-byte write-enable and transfer-acknowledge strobes that an external L2 cache data SRAM needs. A two-bit mode field picks one of four write timings. Mode 00 is plain full-width writing. Mode 01 allows byte-level partial updates. Mode 10 keeps byte updates but returns the bus acknowledge one cycle late, which gives outside logic time to decode the byte lanes. Mode 11 raises the write enable one cycle ahead of the chip select.

A configuration bit marks the SRAM as asynchronous. In that case only the full-width mode is legal, and a request made in any other mode is refused with a one-cycle error pulse. Two polarity bits set the active level of the cache status pins. One covers tag-valid and both dirty signals. The other covers hit. The block translates those pins to and from active-high internal levels.

A request is taken only while the sequencer is idle. The mode, byte enables and dirty mark are captured at the moment the request is accepted.

Top module: `l2_wr_seq`

## Requirements
- R1: In mode 00 every byte write enable asserts (active low) in the first cycle after acceptance, whatever the byte enables are. Transfer acknowledge is high in that same cycle, and every strobe is inactive the cycle after.
- R2: In mode 01, byte write enable lane i asserts only when byte enable bit i was 1 at acceptance. Acknowledge goes high in the same cycle as the write enables, and that strobe cycle lasts one cycle.
- R3: In mode 10, chip select and the selected write enables assert in the first cycle after acceptance with acknowledge low. In the next cycle acknowledge is high and chip select and the write enables are inactive.
- R4: In mode 11, the selected write enables assert alone in the first cycle after acceptance, with chip select high and no acknowledge. In the second cycle chip select and the write enables are asserted together with acknowledge.
- R5: When the asynchronous bit is 1 and the mode is not 00, an accepted request yields err_o high for exactly one cycle. It yields no chip select, no write enable and no acknowledge.
- R6: When the asynchronous bit is 1 and the mode is 00, the write proceeds exactly as in R1, with no error.
- R7: The status polarity bit (0 = active low, 1 = active high) applies to the tag-valid output, the dirty output and the dirty input. Tag-valid is active during the chip-select cycle. Dirty out is active in that cycle only if the request's dirty mark was 1. dirty_o reports the input's active state as a 1.
- R8: The hit polarity bit (0 = active low, 1 = active high) governs the hit input, and hit_o is 1 exactly when the pin is at its active level.
- R9: busy_o is high from the cycle after acceptance until the sequence ends. A request present while busy is ignored, and byte enables that change after acceptance do not affect the write in progress.
- R10: During reset all RAM strobes are inactive (high), acknowledge, error and busy are low, and tag-valid and dirty out sit at their inactive level.
- R11: Output enable stays high (inactive) at all times during write sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wmode_i | input | 2 | Write timing mode |
| cfg_async_i | input | 1 | SRAM is asynchronous |
| cfg_stat_pol_i | input | 1 | Active level of tag-valid and dirty pins |
| cfg_hit_pol_i | input | 1 | Active level of hit pin |
| req_i | input | 1 | Write request |
| be_i | input | NB | Byte enables |
| mark_dirty_i | input | 1 | Line becomes dirty with this write |
| hit_pin_i | input | 1 | Raw hit pin |
| dirty_pin_i | input | 1 | Raw dirty-in pin |
| busy_o | output | 1 | Sequence in progress |
| ce_no | output | 1 | SRAM chip select, active low |
| oe_no | output | 1 | SRAM output enable, active low |
| dwe_no | output | NB | Per-byte write enables, active low |
| ta_o | output | 1 | Transfer acknowledge to bus |
| err_o | output | 1 | Illegal mode for asynchronous SRAM |
| tv_pin_o | output | 1 | Tag-valid pin, configured polarity |
| dirty_pin_o | output | 1 | Dirty-out pin, configured polarity |
| hit_o | output | 1 | Hit, normalised active high |
| dirty_o | output | 1 | Dirty-in, normalised active high |

## Verification
A wrong sequencer state appears at the pins within one cycle of acceptance. Examples are a missed early phase, a stuck hold phase, or a rejected request treated as legal. Each shows as a strobe pattern shifted by a cycle, an acknowledge in the wrong cycle, or an err_o pulse missing or extra. The scoreboard compares every cycle from the request to the return to idle, so such a slip is caught on the first wrong cycle. Byte enables are changed while the sequencer is busy, which exposes a wrong capture of the lanes. Both polarity settings are driven, which exposes an inverted or swapped pin mapping.

// File: rtl/l2ws_pkg.sv
package l2ws_pkg;
  typedef enum logic [1:0] {
    WM_FULL  = 2'b00,
    WM_PART  = 2'b01,
    WM_DELAY = 2'b10,
    WM_EARLY = 2'b11
  } wmode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EARLY,
    ST_STROBE,
    ST_HOLD,
    ST_REJ
  } seq_st_e;
endpackage

// File: rtl/l2ws_fsm.sv
module l2ws_fsm
  import l2ws_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [1:0]    mode_i,
  input  logic          async_i,
  input  logic [NB-1:0] be_i,
  input  logic          dirty_i,
  output seq_st_e       st_o,
  output wmode_e        mode_q_o,
  output logic [NB-1:0] be_q_o,
  output logic          dirty_q_o,
  output logic          busy_o
);
  localparam logic [NB-1:0] BE_ALL = {NB{1'b1}};

  seq_st_e st_q, st_d;
  wmode_e  mode_q;
  logic [NB-1:0] be_q;
  logic dirty_q;
  logic accept, bad_mode;

  assign accept   = req_i && (st_q == ST_IDLE);
  assign bad_mode = async_i && (mode_i != WM_FULL);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        if (bad_mode)               st_d = ST_REJ;
        else if (mode_i == WM_EARLY) st_d = ST_EARLY;
        else                        st_d = ST_STROBE;
      end
      ST_EARLY:  st_d = ST_STROBE;
      ST_STROBE: st_d = (mode_q == WM_DELAY) ? ST_HOLD : ST_IDLE;
      ST_HOLD:   st_d = ST_IDLE;
      ST_REJ:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      mode_q  <= WM_FULL;
      be_q    <= '0;
      dirty_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        mode_q  <= wmode_e'(mode_i);
        // full-width mode ignores byte enables
        be_q    <= (mode_i == WM_FULL) ? BE_ALL : be_i;
        dirty_q <= dirty_i;
      end
    end
  end

  assign st_o      = st_q;
  assign mode_q_o  = mode_q;
  assign be_q_o    = be_q;
  assign dirty_q_o = dirty_q;
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/l2ws_strobe.sv
module l2ws_strobe
  import l2ws_pkg::*;
#(
  parameter int NB = 4
) (
  input  seq_st_e       st_i,
  input  wmode_e        mode_i,
  input  logic [NB-1:0] be_i,
  input  logic          dirty_i,
  output logic          ce_no,
  output logic          oe_no,
  output logic [NB-1:0] dwe_no,
  output logic          ta_o,
  output logic          err_o,
  output logic          tv_o,
  output logic          dirty_o
);
  logic ce_on, we_on;

  assign ce_on = (st_i == ST_STROBE);
  assign we_on = (st_i == ST_STROBE) || (st_i == ST_EARLY);

  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign dwe_no[i] = !(we_on && be_i[i]);
  end

  assign ce_no   = !ce_on;
  assign oe_no   = 1'b1;
  assign ta_o    = (ce_on && (mode_i != WM_DELAY)) || (st_i == ST_HOLD);
  assign err_o   = (st_i == ST_REJ);
  assign tv_o    = ce_on;
  assign dirty_o = ce_on && dirty_i;
endmodule

// File: rtl/l2ws_pol.sv
module l2ws_pol #(
  parameter int N = 1
) (
  input  logic         pol_i,
  input  logic [N-1:0] a_i,
  output logic [N-1:0] y_o
);
  // pol=1: pass, pol=0: invert (same map both directions)
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign y_o[i] = a_i[i] ~^ pol_i;
  end
endmodule

// File: rtl/l2_wr_seq.sv
module l2_wr_seq
  import l2ws_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [1:0]    cfg_wmode_i,
  input  logic          cfg_async_i,
  input  logic          cfg_stat_pol_i,
  input  logic          cfg_hit_pol_i,
  input  logic          req_i,
  input  logic [NB-1:0] be_i,
  input  logic          mark_dirty_i,
  input  logic          hit_pin_i,
  input  logic          dirty_pin_i,
  output logic          busy_o,
  output logic          ce_no,
  output logic          oe_no,
  output logic [NB-1:0] dwe_no,
  output logic          ta_o,
  output logic          err_o,
  output logic          tv_pin_o,
  output logic          dirty_pin_o,
  output logic          hit_o,
  output logic          dirty_o
);
  seq_st_e       st;
  wmode_e        mode_q;
  logic [NB-1:0] be_q;
  logic          dirty_q;
  logic          tv_l, dirty_l;

  l2ws_fsm #(.NB(NB)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .mode_i   (cfg_wmode_i),
    .async_i  (cfg_async_i),
    .be_i     (be_i),
    .dirty_i  (mark_dirty_i),
    .st_o     (st),
    .mode_q_o (mode_q),
    .be_q_o   (be_q),
    .dirty_q_o(dirty_q),
    .busy_o   (busy_o)
  );

  l2ws_strobe #(.NB(NB)) u_strobe (
    .st_i   (st),
    .mode_i (mode_q),
    .be_i   (be_q),
    .dirty_i(dirty_q),
    .ce_no  (ce_no),
    .oe_no  (oe_no),
    .dwe_no (dwe_no),
    .ta_o   (ta_o),
    .err_o  (err_o),
    .tv_o   (tv_l),
    .dirty_o(dirty_l)
  );

  l2ws_pol #(.N(2)) u_stat_out (
    .pol_i(cfg_stat_pol_i),
    .a_i  ({tv_l, dirty_l}),
    .y_o  ({tv_pin_o, dirty_pin_o})
  );

  l2ws_pol #(.N(1)) u_dirty_in (
    .pol_i(cfg_stat_pol_i),
    .a_i  (dirty_pin_i),
    .y_o  (dirty_o)
  );

  l2ws_pol #(.N(1)) u_hit_in (
    .pol_i(cfg_hit_pol_i),
    .a_i  (hit_pin_i),
    .y_o  (hit_o)
  );
endmodule

// File: rtl/l2_wr_seq_chk.sv
module l2_wr_seq_chk #(
  parameter int NB = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          ce_no,
  input logic          oe_no,
  input logic [NB-1:0] dwe_no,
  input logic          ta_o,
  input logic          err_o
);
  // R1/R2/R3/R4: acknowledge only in or right after a chip-select cycle
  a_r3_ta_near_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ta_o |-> (!ce_no || $past(!ce_no)));

  // R1: chip select lasts a single cycle
  a_r1_ce_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_no |=> ce_no);

  // R9: strobes only while busy
  a_r9_ce_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_no || !(&dwe_no)) |-> busy_o);

  // R5: rejection drives no strobe and no acknowledge
  a_r5_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ce_no && (&dwe_no) && !ta_o));

  // R5: error is a one-cycle pulse
  a_r5_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  // R11: output enable never active with chip select
  a_r11_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_no |-> oe_no);

  // R10: reset state
  a_r10_reset: assert property (@(posedge clk_i)
    !rst_ni |-> (ce_no && (&dwe_no) && !ta_o && !err_o && !busy_o));
endmodule

bind l2_wr_seq l2_wr_seq_chk #(.NB(NB)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .busy_o(busy_o),
  .ce_no (ce_no),
  .oe_no (oe_no),
  .dwe_no(dwe_no),
  .ta_o  (ta_o),
  .err_o (err_o)
);

// File: tb/l2_wr_seq_tb.sv
module l2_wr_seq_tb;
  localparam int NB = 4;

  typedef struct packed {
    logic          ce_n;
    logic          oe_n;
    logic [NB-1:0] dwe_n;
    logic          ta;
    logic          err;
    logic          busy;
    logic          tv;
    logic          dirty;
  } obs_t;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] cfg_wmode_i = 2'b00;
  logic cfg_async_i = 1'b0, cfg_stat_pol_i = 1'b0, cfg_hit_pol_i = 1'b0;
  logic req_i = 1'b0, mark_dirty_i = 1'b0, hit_pin_i = 1'b0, dirty_pin_i = 1'b0;
  logic [NB-1:0] be_i = '0;
  logic busy_o, ce_no, oe_no, ta_o, err_o, tv_pin_o, dirty_pin_o, hit_o, dirty_o;
  logic [NB-1:0] dwe_no;

  int n_cmp = 0, n_bad = 0;
  obs_t  exp_q[$];
  string tag_q[$];
  bit    done = 1'b0;

  always #5 clk_i = ~clk_i;

  l2_wr_seq #(.NB(NB)) u_dut (.*);

  function automatic obs_t mk(logic ce, logic [NB-1:0] we, logic ta, logic err,
                              logic busy, logic tv, logic dty);
    obs_t o;
    o.ce_n  = ~ce;
    o.oe_n  = 1'b1;
    o.dwe_n = ~we;
    o.ta    = ta;
    o.err   = err;
    o.busy  = busy;
    o.tv    = tv  ~^ cfg_stat_pol_i;
    o.dirty = dty ~^ cfg_stat_pol_i;
    return o;
  endfunction

  function automatic obs_t cur();
    return '{ce_n: ce_no, oe_n: oe_no, dwe_n: dwe_no, ta: ta_o, err: err_o,
             busy: busy_o, tv: tv_pin_o, dirty: dirty_pin_o};
  endfunction

  task automatic push(obs_t o, string t);
    exp_q.push_back(o);
    tag_q.push_back(t);
  endtask

  task automatic chk1(string t, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", t, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && exp_q.size() > 0) begin
      obs_t e;
      obs_t a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = cur();
      n_cmp++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s act=%b exp=%b", t, a, e);
      end
    end
  end

  task automatic drain();
    while (exp_q.size() > 0) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // driver: one write, expected per-cycle trace queued
  task automatic wr(logic [1:0] mode, logic async, logic [NB-1:0] be, logic dty, string t);
    logic [NB-1:0] lanes;
    @(posedge clk_i); #2;
    cfg_wmode_i = mode; cfg_async_i = async; be_i = be; mark_dirty_i = dty; req_i = 1'b1;
    lanes = (mode == 2'b00) ? '1 : be;
    push(mk(0, '0, 0, 0, 0, 0, 0), t);
    if (async && mode != 2'b00) begin
      push(mk(0, '0, 0, 1, 1, 0, 0), t);
    end else begin
      case (mode)
        2'b10: begin
          push(mk(1, lanes, 0, 0, 1, 1, dty), t);
          push(mk(0, '0, 1, 0, 1, 0, 0), t);
        end
        2'b11: begin
          push(mk(0, lanes, 0, 0, 1, 0, 0), t);
          push(mk(1, lanes, 1, 0, 1, 1, dty), t);
        end
        default: push(mk(1, lanes, 1, 0, 1, 1, dty), t);
      endcase
    end
    push(mk(0, '0, 0, 0, 0, 0, 0), t);
    @(posedge clk_i); #2;
    req_i = 1'b0; be_i = ~be;
    drain();
  endtask

  initial begin
    #(200000 * 10);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #23;
    // R10: reset state
    chk1("R10 reset strobes", {ce_no, oe_no, dwe_no}, {2'b11, {NB{1'b1}}});
    chk1("R10 reset ta/err/busy", {ta_o, err_o, busy_o}, 3'b000);
    chk1("R10 reset tv/dirty idle level", {tv_pin_o, dirty_pin_o}, 2'b11);
    rst_ni = 1'b1;

    wr(2'b00, 0, 4'b0010, 1, "R1 mode00 full width");
    wr(2'b00, 0, 4'b0000, 0, "R1 mode00 no be");
    wr(2'b01, 0, 4'b0101, 1, "R2 mode01 partial");
    wr(2'b01, 0, 4'b1000, 0, "R2 mode01 single lane");
    wr(2'b10, 0, 4'b0011, 1, "R3 mode10 delayed ta");
    wr(2'b11, 0, 4'b1100, 1, "R4 mode11 early dwe");
    wr(2'b11, 0, 4'b1111, 0, "R4 mode11 all lanes");
    wr(2'b01, 1, 4'b1111, 1, "R5 async mode01 rejected");
    wr(2'b10, 1, 4'b0001, 0, "R5 async mode10 rejected");
    wr(2'b11, 1, 4'b0110, 1, "R5 async mode11 rejected");
    wr(2'b00, 1, 4'b0001, 1, "R6 async mode00 legal");

    // R7: active-high status pins
    cfg_stat_pol_i = 1'b1;
    wr(2'b01, 0, 4'b1001, 1, "R7 stat pol high dirty");
    wr(2'b10, 0, 4'b0110, 0, "R7 stat pol high clean");
    dirty_pin_i = 1'b1; #1 chk1("R7 dirty in pol1 pin1", dirty_o, 1);
    dirty_pin_i = 1'b0; #1 chk1("R7 dirty in pol1 pin0", dirty_o, 0);
    cfg_stat_pol_i = 1'b0;
    #1 chk1("R7 dirty in pol0 pin0", dirty_o, 1);
    dirty_pin_i = 1'b1; #1 chk1("R7 dirty in pol0 pin1", dirty_o, 0);

    // R8: hit polarity
    hit_pin_i = 1'b0; #1 chk1("R8 hit pol0 pin0", hit_o, 1);
    hit_pin_i = 1'b1; #1 chk1("R8 hit pol0 pin1", hit_o, 0);
    cfg_hit_pol_i = 1'b1;
    #1 chk1("R8 hit pol1 pin1", hit_o, 1);
    hit_pin_i = 1'b0; #1 chk1("R8 hit pol1 pin0", hit_o, 0);

    // R9: request held while busy, be changed after accept
    @(posedge clk_i); #2;
    cfg_wmode_i = 2'b10; cfg_async_i = 0; be_i = 4'b0001; mark_dirty_i = 0; req_i = 1'b1;
    push(mk(0, '0, 0, 0, 0, 0, 0), "R9 hold idle");
    push(mk(1, 4'b0001, 0, 0, 1, 1, 0), "R9 hold strobe latched be");
    push(mk(0, '0, 1, 0, 1, 0, 0), "R9 hold ignored req");
    push(mk(0, '0, 0, 0, 0, 0, 0), "R9 hold back idle");
    @(posedge clk_i); #2;
    be_i = 4'b1110;
    @(posedge clk_i); #2;
    req_i = 1'b0;
    drain();

    // R11 covered in each trace by oe_n expected high
    chk1("R11 oe idle", oe_no, 1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule